// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 interrupt request lines into one processor interrupt. Each line is fixed at build time as edge-triggered or level-triggered. A captured request is held in a status register until software acknowledges it. An enable register decides which captured requests count as pending, and a two-bit master control gates both the capture of requests and the processor interrupt output.

Software reaches the block through a single-cycle 32-bit register port. The port has a byte address, a write strobe with write data, and a read strobe. Read data appears on the clock after the read strobe.

Enable bits can be changed one at a time without a read-modify-write. Writing a mask to one offset sets those bits, and writing a mask to another offset clears them. A vector register returns the number of the pending source to service, so a handler can dispatch without scanning the pending bits itself.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the status, enable and master registers read zero. `irq_out` is low and the vector reads 0xFFFFFFFF.
- R2: A write to 0x08 loads the enable register directly. A write to 0x10 ORs the data into the enable register. A write to 0x14 clears the enable bits where the data is 1. Zero data bits leave enable bits unchanged.
- R3: A write to 0x0C clears every status bit whose data bit is 1, and leaves the others unchanged.
- R4: The master register at 0x1C uses bit 1 to let inputs set status bits and bit 0 to allow the output. `irq_out` is high one cycle after both bits are 1 and the pending value is nonzero, and low otherwise.
- R5: When bit i of `EDGE_KIND` is 1, input i sets its status bit only on a low-to-high transition. When bit i is 0, input i sets its status bit on every cycle it is high.
- R6: If a level input is still high when it is acknowledged, its status bit stays set.
- R7: A read of 0x18 returns the lowest-numbered pending source, so bit 0 has the highest priority. It returns 0xFFFFFFFF when nothing is pending.
- R8: A read of 0x00 returns the status register. A read of 0x04 returns status AND enable.
- R9: If a source sets its status bit in the same cycle that an acknowledge clears it, the bit ends up set.
- R10: Writes to 0x00, 0x04 and 0x18 have no effect. Reads of 0x0C, 0x10 and 0x14 return zero.
- R11: Writing zero to 0x08 masks every source and leaves the status and master registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 5 | Byte address of the register; bits 4:2 select it |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid on the cycle after `bus_rd` |
| irq_in | input | N_SRC | Interrupt request lines |
| irq_out | output | 1 | Processor interrupt, active high, registered |

## Verification
Two operations can hit the same status bit in one cycle: a source setting it and a software acknowledge clearing it. The bench provokes this by raising an edge line and holding a level line high during the very cycle an acknowledge write strobes those bits. It then reads status and expects both bits set. It also sweeps every enable pattern and every acknowledge mask on an eight-input build, with inputs 4 to 7 edge-triggered. Pending, vector and output values are computed arithmetically in the bench.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int BUS_W = 32;
  localparam int ADDR_W = 5;

  typedef enum logic [2:0] {
    SEL_STAT  = 3'd0,
    SEL_PEND  = 3'd1,
    SEL_EN    = 3'd2,
    SEL_ACK   = 3'd3,
    SEL_SETEN = 3'd4,
    SEL_CLREN = 3'd5,
    SEL_VEC   = 3'd6,
    SEL_MSTR  = 3'd7
  } reg_sel_e;

  localparam int MSTR_OUT_BIT = 0;
  localparam int MSTR_HW_BIT  = 1;
endpackage

// File: rtl/vic_src_capture.sv
module vic_src_capture #(
  parameter int N_SRC = 32,
  parameter logic [N_SRC-1:0] EDGE_KIND = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] irq_in,
  input  logic             hw_on,
  input  logic [N_SRC-1:0] ack_i,
  output logic [N_SRC-1:0] status_o
);
  logic [N_SRC-1:0] in_q;
  logic [N_SRC-1:0] set_v;
  logic [N_SRC-1:0] status_q;
  logic             unused_inq;

  assign unused_inq = ^in_q;

  always_ff @(posedge clk) begin
    if (rst) in_q <= '0;
    else     in_q <= irq_in;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (EDGE_KIND[i]) begin : g_edge
      assign set_v[i] = hw_on & irq_in[i] & ~in_q[i];
    end else begin : g_lvl
      assign set_v[i] = hw_on & irq_in[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= (status_q & ~ack_i) | set_v;
  end

  assign status_o = status_q;

  // R9: a new request wins against an acknowledge in the same cycle
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (set_v != '0) |=> ((status_q & $past(set_v)) == $past(set_v)));

  // R3: acknowledged bits without a new request read zero afterwards
  a_r3_ack_clears: assert property (@(posedge clk) disable iff (rst)
    ((ack_i & ~set_v) != '0) |=> ((status_q & $past(ack_i & ~set_v)) == '0));

  // R4: with inputs gated off no status bit can appear
  a_r4_hw_gate: assert property (@(posedge clk) disable iff (rst)
    !hw_on |=> ((status_q & ~$past(status_q)) == '0));
endmodule

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int N_SRC = 32,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] pend_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import vic_pkg::*;
#(
  parameter int N_SRC = 32,
  parameter logic [N_SRC-1:0] EDGE_KIND = '0,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [N_SRC-1:0]  irq_in,
  output logic              irq_out
);
  reg_sel_e         sel;
  logic [N_SRC-1:0] wmask;
  logic [N_SRC-1:0] en_q;
  logic [1:0]       mstr_q;
  logic [N_SRC-1:0] ack_v;
  logic [N_SRC-1:0] status;
  logic [N_SRC-1:0] pend;
  logic             enc_found;
  logic [IDX_W-1:0] enc_idx;
  logic [BUS_W-1:0] vec_val;
  logic [BUS_W-1:0] rd_mux;
  logic [BUS_W-1:0] rdata_q;
  logic             irq_q;
  logic             unused_bus;

  assign sel        = reg_sel_e'(bus_addr[4:2]);
  assign wmask      = bus_wdata[N_SRC-1:0];
  assign unused_bus = ^{bus_addr[1:0], bus_wdata};

  assign ack_v = (bus_wr && sel == SEL_ACK) ? wmask : '0;

  vic_src_capture #(.N_SRC(N_SRC), .EDGE_KIND(EDGE_KIND)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .irq_in   (irq_in),
    .hw_on    (mstr_q[MSTR_HW_BIT]),
    .ack_i    (ack_v),
    .status_o (status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      mstr_q <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_EN:    en_q   <= wmask;
        SEL_SETEN: en_q   <= en_q | wmask;
        SEL_CLREN: en_q   <= en_q & ~wmask;
        SEL_MSTR:  mstr_q <= bus_wdata[1:0];
        default:   ;
      endcase
    end
  end

  assign pend = status & en_q;

  vic_prio_enc #(.N_SRC(N_SRC)) u_enc (
    .pend_i  (pend),
    .found_o (enc_found),
    .idx_o   (enc_idx)
  );

  assign vec_val = enc_found ? BUS_W'(enc_idx) : '1;

  always_comb begin
    case (sel)
      SEL_STAT: rd_mux = BUS_W'(status);
      SEL_PEND: rd_mux = BUS_W'(pend);
      SEL_EN:   rd_mux = BUS_W'(en_q);
      SEL_VEC:  rd_mux = vec_val;
      SEL_MSTR: rd_mux = BUS_W'(mstr_q);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (bus_rd) rdata_q <= rd_mux;
      irq_q <= (mstr_q == 2'b11) && (pend != '0);
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_out   = irq_q;

  // R2: set-enable leaves every written one set in the enable register
  a_r2_set_en: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == SEL_SETEN) |=> ((en_q & $past(wmask)) == $past(wmask)));

  // R2: clear-enable leaves every written one cleared
  a_r2_clr_en: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel == SEL_CLREN) |=> ((en_q & $past(wmask)) == '0));

  // R4: output only follows a cycle with both master bits on
  a_r4_out_gate: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ($past(mstr_q) == 2'b11));

  // R7: encoder picks a pending bit with no lower pending bit
  a_r7_vec_lowest: assert property (@(posedge clk) disable iff (rst)
    enc_found |-> (pend[enc_idx] && ((pend & ((N_SRC'(1) << enc_idx) - N_SRC'(1))) == '0)));

  // R10: write-only offsets read back zero
  a_r10_wo_read: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (sel == SEL_ACK || sel == SEL_SETEN || sel == SEL_CLREN)) |=> (bus_rdata == '0));
endmodule

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam logic [N-1:0] KIND = 8'hF0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [N-1:0] irq_in = '0;
  logic        irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_ctrl #(.N_SRC(N), .EDGE_KIND(KIND)) u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    @(negedge clk);
    irq_in = m;
    @(negedge clk);
    irq_in = '0;
  endtask

  function automatic logic [31:0] lowest(input logic [N-1:0] p);
    logic [31:0] r = 32'hFFFF_FFFF;
    for (int i = N - 1; i >= 0; i--) if (p[i]) r = i;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq_out", {31'd0, irq_out}, 32'd0);
    rd(5'h00, d); chk("R1 status", d, 32'd0);
    rd(5'h08, d); chk("R1 enable", d, 32'd0);
    rd(5'h1C, d); chk("R1 master", d, 32'd0);
    rd(5'h18, d); chk("R1 vector", d, 32'hFFFF_FFFF);

    // R4 inputs gated while master bit 1 is off
    pulse(8'hFF);
    rd(5'h00, d); chk("R4 hw gate", d, 32'd0);

    wr(5'h1C, 32'h3);
    rd(5'h1C, d); chk("R4 master rb", d, 32'h3);

    // R5 every kind captures a pulse
    pulse(8'hFF);
    rd(5'h00, d); chk("R5 capture all", d, 32'hFF);
    wr(5'h0C, 32'hFF);
    rd(5'h00, d); chk("R3 ack all", d, 32'd0);

    // R5/R6 held lines: edges do not re-set, levels do
    @(negedge clk); irq_in = 8'hFF;
    repeat (2) @(negedge clk);
    wr(5'h0C, 32'hFF);
    rd(5'h00, d); chk("R6 level reappears", d, 32'h0F);
    @(negedge clk); irq_in = '0;
    wr(5'h0C, 32'hFF);
    rd(5'h00, d); chk("R5 after drop", d, 32'd0);

    // R2 R7 R8 R4 sweep of enable patterns with full status
    pulse(8'hFF);
    for (int v = 0; v < 256; v++) begin
      wr(5'h08, v);
      rd(5'h04, d); chk("R8 pending", d, v);
      rd(5'h18, d); chk("R7 vector", d, lowest(v[N-1:0]));
      chk("R4 irq_out", {31'd0, irq_out}, {31'd0, (v != 0)});
    end
    rd(5'h00, d); chk("R8 status", d, 32'hFF);

    // R2 set and clear
    wr(5'h08, 32'h0F);
    wr(5'h10, 32'h30);
    rd(5'h08, d); chk("R2 set-enable", d, 32'h3F);
    wr(5'h14, 32'h05);
    rd(5'h08, d); chk("R2 clear-enable", d, 32'h3A);

    // R11 zero enable
    wr(5'h08, 32'h0);
    rd(5'h08, d); chk("R11 enable", d, 32'd0);
    rd(5'h00, d); chk("R11 status kept", d, 32'hFF);
    rd(5'h1C, d); chk("R11 master kept", d, 32'h3);
    chk("R11 irq_out", {31'd0, irq_out}, 32'd0);

    // R10 ignored writes and write-only reads
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0);
    wr(5'h18, 32'h0);
    rd(5'h00, d); chk("R10 status unchanged", d, 32'hFF);
    rd(5'h0C, d); chk("R10 ack reads 0", d, 32'd0);
    rd(5'h10, d); chk("R10 seten reads 0", d, 32'd0);
    rd(5'h14, d); chk("R10 clren reads 0", d, 32'd0);

    // R3 sweep of acknowledge masks
    for (int a = 0; a < 256; a++) begin
      pulse(8'hFF);
      wr(5'h0C, a);
      rd(5'h00, d); chk("R3 ack mask", d, (~a) & 32'hFF);
    end

    // R9 set and ack in the same cycle (edge bit 4, level bit 1)
    wr(5'h0C, 32'hFF);
    @(negedge clk);
    irq_in = 8'h12;
    bus_addr = 5'h0C; bus_wdata = 32'h12; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; irq_in = '0;
    rd(5'h00, d); chk("R9 set wins", d, 32'h12);

    // R4 each master bit alone blocks output
    wr(5'h08, 32'hFF);
    wr(5'h1C, 32'h2);
    repeat (2) @(negedge clk);
    chk("R4 out bit off", {31'd0, irq_out}, 32'd0);
    wr(5'h1C, 32'h1);
    repeat (2) @(negedge clk);
    chk("R4 hw bit off", {31'd0, irq_out}, 32'd0);
    wr(5'h1C, 32'h3);
    repeat (2) @(negedge clk);
    chk("R4 both on", {31'd0, irq_out}, 32'd1);
    rd(5'h18, d); chk("R7 vector bit1", d, 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule